// File: doc/BRIEF.md
# SD Card SPI Data Block Mover

This block runs the data phase of a memory-card transfer in SPI mode, once a read, write or stop command has already been accepted by the card. It never drives the SPI wires itself. Every bus byte goes through a byte-exchange port: the block raises a request with a byte to send, and an external shifter answers with an acknowledge and the byte it clocked in.

A read watches for the start-of-data marker. It hands each payload byte to a valid/ready output stream and then reads and discards the two trailing check bytes. A write first waits until the card stops signalling busy. It then sends a caller-chosen token, the payload taken from a valid/ready input stream, two filler check bytes, and finally reads the card's data-response byte and judges it. A stop transfer waits for ready and sends the stop marker alone.

The payload length comes with each request, so 512-byte sectors and 16-byte register blocks use the same path. Each transfer ends with a one-cycle completion pulse that carries either a success flag or a failure flag.

Top module: `sd_blk_xfer`

## Requirements
- R1: While reset is asserted and after it is released, done, ok, err, x_req, rd_valid and wr_ready are all low until a start is given.
- R2: mode encoding: 0 read, 1 write, 2 stop, 3 reserved. In a read, received 0xFF bytes are skipped while hunting. The first other byte must be 0xFE. Any other value ends the transfer with err and no payload byte is emitted.
- R3: After 0xFE, a read emits exactly count received bytes on rd_data in arrival order. It then performs exactly two more exchanges, whose received bytes are discarded, and ends with ok. Every byte sent during a read is 0xFF.
- R4: When rd_ready is low, no received byte is lost or overwritten. A pending rd_data stays valid and stable until it is taken.
- R5: If the read hunt still sees only 0xFF once TOKEN_WAIT cycles have elapsed, the transfer ends with err.
- R6: Write and stop transfers first send 0xFF until 0xFF is received. If that has not happened by BUSY_WAIT cycles, the transfer ends with err.
- R7: A write then sends wtoken, then count bytes taken in order from the write stream, then 0xFF twice, then one 0xFF exchange that reads the response. Every exchange request holds x_tx stable until acknowledged.
- R8: A write ends with ok exactly when bits 4:0 of the response byte equal 0x05, and with err otherwise.
- R9: A stop transfer sends 0xFD once after the ready wait. It sends no payload and no check bytes, reads no response, and ends with ok. The count input is not used.
- R10: A read or write with count zero or odd, or with the reserved mode, ends with done and err in the cycle after start, with no exchange.
- R11: done is a single-cycle pulse. Exactly one of ok and err is high with it, and both are low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (sampled while idle) |
| mode | input | 2 | 0 read, 1 write, 2 stop, 3 reserved |
| wtoken | input | 8 | Token sent before write payload |
| count | input | COUNT_W | Payload byte count (even, nonzero) |
| done | output | 1 | Transfer finished (one cycle) |
| ok | output | 1 | Finished successfully, with done |
| err | output | 1 | Finished with failure, with done |
| x_req | output | 1 | Byte exchange request |
| x_tx | output | 8 | Byte to shift out |
| x_ack | input | 1 | Exchange complete this cycle |
| x_rx | input | 8 | Byte shifted in, valid with x_ack |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | rd_data is valid |
| rd_ready | input | 1 | Consumer takes rd_data |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | wr_data is valid |
| wr_ready | output | 1 | Block takes wr_data this cycle |

## Verification
The hardest state to reach is a read whose consumer stalls at the same moment the next card byte is due. A single held byte has to block further exchanges without losing the last payload byte, and it must still let the two discarded check bytes run while the consumer is stalled. The bench reaches this with a full 512-byte read, and in a short one, by pulling rd_ready low for two cycles out of every three. Meanwhile the card model acknowledges every other cycle, so stalls land at every phase of the exchange handshake. The timeout paths are reached by building the bench with short wait limits and scripting the card to never release the bus.

// File: rtl/sd_blk_pkg.sv
package sd_blk_pkg;
   typedef enum logic [1:0] {
      XM_READ  = 2'd0,
      XM_WRITE = 2'd1,
      XM_STOP  = 2'd2,
      XM_RSVD  = 2'd3
   } xfer_mode_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HUNT,
      ST_RDATA,
      ST_CHK,
      ST_BUSY,
      ST_TOK,
      ST_WDATA,
      ST_RESP,
      ST_FIN
   } xfer_st_e;

   localparam logic [7:0] FILL_BYTE   = 8'hFF;
   localparam logic [7:0] START_MARK  = 8'hFE;
   localparam logic [7:0] STOP_MARK   = 8'hFD;
   localparam logic [4:0] RESP_ACCEPT = 5'h05;
endpackage

// File: rtl/sd_blk_wdog.sv
module sd_blk_wdog #(
   parameter int LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   logic [W-1:0] ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ticks <= '0;
      else if (!run)           ticks <= '0;
      else if (ticks != LIM_V) ticks <= ticks + 1'b1;
   end

   assign expired = (ticks == LIM_V);
endmodule

// File: rtl/sd_blk_rxhold.sv
module sd_blk_rxhold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   output logic          valid,
   output logic [DW-1:0] dout,
   input  logic          ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
   import sd_blk_pkg::*;
#(
   parameter int COUNT_W    = 10,
   parameter int TOKEN_WAIT = 5000000,
   parameter int BUSY_WAIT  = 25000000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [1:0]         mode,
   input  logic [7:0]         wtoken,
   input  logic [COUNT_W-1:0] count,
   output logic               done,
   output logic               ok,
   output logic               err,
   output logic               x_req,
   output logic [7:0]         x_tx,
   input  logic               x_ack,
   input  logic [7:0]         x_rx,
   output logic [7:0]         rd_data,
   output logic               rd_valid,
   input  logic               rd_ready,
   input  logic [7:0]         wr_data,
   input  logic               wr_valid,
   output logic               wr_ready
);
   localparam int NPHASE = 2;
   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   generate
      if (COUNT_W < 2) begin : g_bad_count_w
         $error("sd_blk_xfer: COUNT_W must be at least 2");
      end
      if (TOKEN_WAIT < 1 || BUSY_WAIT < 1) begin : g_bad_wait
         $error("sd_blk_xfer: wait limits must be positive");
      end
   endgenerate

   xfer_st_e           st;
   xfer_mode_e         mode_q;
   logic [7:0]         tok_q;
   logic [COUNT_W-1:0] left;
   logic               chk_second;
   logic               res_ok;
   logic               fire;
   logic               hold_load;
   logic               idle_s;
   logic [NPHASE-1:0]  phase_run;
   logic [NPHASE-1:0]  phase_exp;
   logic               bad_len;

   assign fire      = x_req & x_ack;
   assign hold_load = (st == ST_RDATA) & fire;
   assign idle_s    = (st == ST_IDLE);
   assign bad_len   = (count == '0) | count[0];

   // phase 0: start-marker hunt, phase 1: busy wait
   generate
      for (genvar i = 0; i < NPHASE; i++) begin : g_phase
         localparam int LIM = (i == 0) ? TOKEN_WAIT : BUSY_WAIT;
         assign phase_run[i] = (i == 0) ? (st == ST_HUNT) : (st == ST_BUSY);
         sd_blk_wdog #(.LIMIT(LIM)) u_wdog (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (phase_run[i]),
            .expired (phase_exp[i])
         );
      end
   endgenerate

   sd_blk_rxhold #(.DW(8)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hold_load),
      .din   (x_rx),
      .valid (rd_valid),
      .dout  (rd_data),
      .ready (rd_ready)
   );

   always_comb begin
      x_req    = 1'b0;
      x_tx     = FILL_BYTE;
      wr_ready = 1'b0;
      unique case (st)
         ST_HUNT, ST_CHK, ST_BUSY, ST_RESP: x_req = 1'b1;
         ST_RDATA: x_req = ~rd_valid;
         ST_TOK: begin
            x_req = 1'b1;
            x_tx  = (mode_q == XM_STOP) ? STOP_MARK : tok_q;
         end
         ST_WDATA: begin
            x_req    = wr_valid;
            x_tx     = wr_data;
            wr_ready = x_ack;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         mode_q     <= XM_READ;
         tok_q      <= '0;
         left       <= '0;
         chk_second <= 1'b0;
         res_ok     <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               mode_q <= xfer_mode_e'(mode);
               tok_q  <= wtoken;
               left   <= count;
               res_ok <= 1'b0;
               unique case (xfer_mode_e'(mode))
                  XM_STOP:  st <= ST_BUSY;
                  XM_READ:  st <= bad_len ? ST_FIN : ST_HUNT;
                  XM_WRITE: st <= bad_len ? ST_FIN : ST_BUSY;
                  default:  st <= ST_FIN;
               endcase
            end
            ST_HUNT: if (fire) begin
               if (x_rx == FILL_BYTE) begin
                  if (phase_exp[0]) st <= ST_FIN;
               end else if (x_rx == START_MARK) begin
                  st <= ST_RDATA;
               end else begin
                  st <= ST_FIN;
               end
            end
            ST_RDATA, ST_WDATA: if (fire) begin
               left <= left - 1'b1;
               if (left == ONE) begin
                  st         <= ST_CHK;
                  chk_second <= 1'b0;
               end
            end
            ST_CHK: if (fire) begin
               chk_second <= 1'b1;
               if (chk_second) begin
                  if (mode_q == XM_READ) begin
                     res_ok <= 1'b1;
                     st     <= ST_FIN;
                  end else begin
                     st <= ST_RESP;
                  end
               end
            end
            ST_BUSY: if (fire) begin
               if (x_rx == FILL_BYTE) st <= ST_TOK;
               else if (phase_exp[1]) st <= ST_FIN;
            end
            ST_TOK: if (fire) begin
               if (mode_q == XM_STOP) begin
                  res_ok <= 1'b1;
                  st     <= ST_FIN;
               end else begin
                  st <= ST_WDATA;
               end
            end
            ST_RESP: if (fire) begin
               res_ok <= (x_rx[4:0] == RESP_ACCEPT);
               st     <= ST_FIN;
            end
            ST_FIN: if (!rd_valid) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done = (st == ST_FIN) & ~rd_valid;
   assign ok   = done & res_ok;
   assign err  = done & ~res_ok;
endmodule

// File: rtl/sd_blk_xfer_chk.sv
module sd_blk_xfer_chk #(
   parameter int COUNT_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic [1:0]         mode,
   input logic [COUNT_W-1:0] count,
   input logic               idle,
   input logic               done,
   input logic               ok,
   input logic               err,
   input logic               x_req,
   input logic               x_ack,
   input logic [7:0]         x_tx,
   input logic               rd_valid,
   input logic               rd_ready,
   input logic [7:0]         rd_data
);
   // R11
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ok ^ err));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!ok && !err));

   // R4
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   // R7
   xreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (x_req && !x_ack) |=> (x_req && $stable(x_tx)));

   // R10
   bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start && mode != 2'd2 && (count == '0 || count[0]))
      |=> (done && err));
endmodule

bind sd_blk_xfer sd_blk_xfer_chk #(.COUNT_W(COUNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .mode     (mode),
   .count    (count),
   .idle     (idle_s),
   .done     (done),
   .ok       (ok),
   .err      (err),
   .x_req    (x_req),
   .x_ack    (x_ack),
   .x_tx     (x_tx),
   .rd_valid (rd_valid),
   .rd_ready (rd_ready),
   .rd_data  (rd_data)
);

// File: tb/tb_sd_blk_xfer.sv
module tb_sd_blk_xfer;
   localparam int CW  = 10;
   localparam int TW  = 40;
   localparam int BW  = 60;
   localparam int MAXB = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic [7:0]    wtoken = 8'h00;
   logic [CW-1:0] count = '0;
   logic          done, ok, err, x_req, rd_valid, wr_ready;
   logic [7:0]    x_tx, rd_data;
   logic          x_ack = 1'b0;
   logic [7:0]    x_rx = 8'hFF;
   logic          rd_ready = 1'b1;
   logic [7:0]    wr_data = 8'h00;
   logic          wr_valid = 1'b0;

   always #4 clk = ~clk;

   sd_blk_xfer #(.COUNT_W(CW), .TOKEN_WAIT(TW), .BUSY_WAIT(BW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wtoken(wtoken),
      .count(count), .done(done), .ok(ok), .err(err), .x_req(x_req),
      .x_tx(x_tx), .x_ack(x_ack), .x_rx(x_rx), .rd_data(rd_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_data(wr_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready)
   );

   int checks = 0;
   int failures = 0;
   logic [7:0] script [MAXB];
   logic [7:0] txlog  [MAXB];
   logic [7:0] rcv    [MAXB];
   int sidx = 0;
   int rcount = 0;
   int widx = 0;
   bit bp = 1'b0;
   int cyc = 0;

   task automatic chk(input bit cond, input string tag, input int act, input int exp);
      checks++;
      if (!cond) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rpat(input int v, input int k);
      return 8'((k * 13 + v * 5 + 1) & 255);
   endfunction

   function automatic logic [7:0] wpat(input int k);
      return 8'((k * 11 + 3) & 255);
   endfunction

   // card model, read sink and write source
   initial begin
      forever begin
         bit wadv;
         @(negedge clk);
         cyc++;
         if (x_ack) x_ack = 1'b0;
         else if (x_req) begin
            x_ack = 1'b1;
            x_rx  = script[sidx % MAXB];
         end
         rd_ready = bp ? (cyc % 3 == 0) : 1'b1;
         #1;
         if (x_ack && x_req) begin
            txlog[sidx % MAXB] = x_tx;
            sidx++;
         end
         if (rd_valid && rd_ready) begin
            rcv[rcount % MAXB] = rd_data;
            rcount++;
         end
         wadv = wr_valid && wr_ready;
         @(posedge clk);
         #1;
         if (wadv) begin
            widx++;
            wr_data = wpat(widx);
         end
      end
   end

   task automatic prep();
      for (int i = 0; i < MAXB; i++) script[i] = 8'hFF;
      sidx = 0; rcount = 0; widx = 0;
      wr_data = wpat(0);
   endtask

   task automatic run(input logic [1:0] md, input int n, input logic [7:0] tk,
                      output int ncyc, output bit gok, output bit gerr);
      bit seen;
      @(posedge clk); #1;
      start = 1'b1; mode = md; count = CW'(n); wtoken = tk;
      wr_valid = (md == 2'd1);
      @(posedge clk); #1;
      start = 1'b0;
      ncyc = 0; gok = 0; gerr = 0; seen = 0;
      while (!seen && ncyc < 3000) begin
         @(negedge clk); #2;
         ncyc++;
         if (done) begin
            seen = 1; gok = ok; gerr = err;
         end
      end
      chk(seen, "R11 done seen", seen, 1);
      @(negedge clk); #2;
      chk(!done && !ok && !err, "R11 done single pulse", {done, ok, err}, 0);
      chk(gok ^ gerr, "R11 one flag", {gok, gerr}, 1);
      wr_valid = 1'b0;
      bp = 1'b0;
   endtask

   typedef struct packed {
      logic [1:0] md;
      logic [9:0] n;
      logic [7:0] tok;
      logic [3:0] lead;
      logic [7:0] first;
      logic [7:0] resp;
      logic       bpv;
      logic       exp_ok;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 10'd16,  8'h00, 4'd3, 8'hFE, 8'h00, 1'b0, 1'b1},
      '{2'd0, 10'd16,  8'h00, 4'd0, 8'hFE, 8'h00, 1'b1, 1'b1},
      '{2'd0, 10'd8,   8'h00, 4'd2, 8'hFC, 8'h00, 1'b0, 1'b0},
      '{2'd1, 10'd16,  8'hFE, 4'd3, 8'h00, 8'hE5, 1'b0, 1'b1},
      '{2'd1, 10'd8,   8'hFC, 4'd0, 8'h00, 8'h0B, 1'b0, 1'b0},
      '{2'd2, 10'd0,   8'h00, 4'd2, 8'h00, 8'h00, 1'b0, 1'b1},
      '{2'd0, 10'd512, 8'h00, 4'd1, 8'hFE, 8'h00, 1'b1, 1'b1}
   };

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int nc;
      bit gok, gerr;
      prep();
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk({done, ok, err, x_req, rd_valid, wr_ready} == 6'b0, "R1 in reset",
          {done, ok, err, x_req, rd_valid, wr_ready}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #2;
      chk({done, ok, err, x_req, rd_valid, wr_ready} == 6'b0, "R1 after reset",
          {done, ok, err, x_req, rd_valid, wr_ready}, 0);

      for (int v = 0; v < NV; v++) begin
         vec_t t = VECS[v];
         int ld = int'(t.lead);
         int n  = int'(t.n);
         int bad;
         int nx;
         prep();
         bp = t.bpv;
         if (t.md == 2'd0) begin
            script[ld] = t.first;
            for (int k = 0; k < n; k++) script[ld + 1 + k] = rpat(v, k);
            script[ld + 1 + n] = 8'h12;
            script[ld + 2 + n] = 8'h34;
         end else begin
            for (int k = 0; k < ld; k++) script[k] = 8'h00;
            if (t.md == 2'd1) script[ld + n + 4] = t.resp;
         end
         run(t.md, n, t.tok, nc, gok, gerr);
         if (t.md == 2'd0) begin
            // R2 R3 R4
            chk(gok == t.exp_ok, $sformatf("R2 R3 vec%0d result", v), gok, t.exp_ok);
            nx = t.exp_ok ? ld + 3 + n : ld + 1;
            chk(sidx == nx, $sformatf("R3 vec%0d exchanges", v), sidx, nx);
            chk(rcount == (t.exp_ok ? n : 0), $sformatf("R2 R4 vec%0d byte count", v),
                rcount, t.exp_ok ? n : 0);
            bad = 0;
            for (int k = 0; k < rcount && k < MAXB; k++) if (rcv[k] !== rpat(v, k)) bad++;
            chk(bad == 0, $sformatf("R3 R4 vec%0d payload", v), bad, 0);
            bad = 0;
            for (int k = 0; k < sidx && k < MAXB; k++) if (txlog[k] !== 8'hFF) bad++;
            chk(bad == 0, $sformatf("R3 vec%0d sent fill", v), bad, 0);
         end else if (t.md == 2'd1) begin
            // R6 R7 R8
            chk(gok == t.exp_ok, $sformatf("R8 vec%0d result", v), gok, t.exp_ok);
            chk(sidx == ld + n + 5, $sformatf("R7 vec%0d exchanges", v), sidx, ld + n + 5);
            bad = 0;
            for (int k = 0; k <= ld; k++) if (txlog[k] !== 8'hFF) bad++;
            chk(bad == 0, $sformatf("R6 vec%0d busy fill", v), bad, 0);
            chk(txlog[ld + 1] == t.tok, $sformatf("R7 vec%0d token", v), txlog[ld + 1], t.tok);
            bad = 0;
            for (int k = 0; k < n; k++) if (txlog[ld + 2 + k] !== wpat(k)) bad++;
            for (int k = 0; k < 3; k++) if (txlog[ld + 2 + n + k] !== 8'hFF) bad++;
            chk(bad == 0, $sformatf("R7 vec%0d payload and trailer", v), bad, 0);
         end else begin
            // R9
            chk(gok, $sformatf("R9 vec%0d result", v), gok, 1);
            chk(sidx == ld + 2, $sformatf("R9 vec%0d exchanges", v), sidx, ld + 2);
            chk(txlog[ld + 1] == 8'hFD, $sformatf("R9 vec%0d stop mark", v), txlog[ld + 1], 8'hFD);
         end
      end

      // R10: zero count, odd count, reserved mode
      prep();
      run(2'd0, 0, 8'h00, nc, gok, gerr);
      chk(gerr && nc == 1 && sidx == 0, "R10 zero count read", {gerr, 4'(nc), 4'(sidx)}, 9'h110);
      prep();
      run(2'd1, 7, 8'hFE, nc, gok, gerr);
      chk(gerr && nc == 1 && sidx == 0, "R10 odd count write", {gerr, 4'(nc), 4'(sidx)}, 9'h110);
      prep();
      run(2'd3, 8, 8'hFE, nc, gok, gerr);
      chk(gerr && nc == 1 && sidx == 0, "R10 reserved mode", {gerr, 4'(nc), 4'(sidx)}, 9'h110);

      // R5: card never sends a marker
      prep();
      run(2'd0, 16, 8'h00, nc, gok, gerr);
      chk(gerr && nc >= TW && nc <= TW + 4, "R5 hunt timeout", nc, TW);
      chk(rcount == 0, "R5 no payload", rcount, 0);

      // R6: card stays busy
      prep();
      for (int k = 0; k < MAXB; k++) script[k] = 8'h00;
      run(2'd1, 16, 8'hFE, nc, gok, gerr);
      chk(gerr && nc >= BW && nc <= BW + 4, "R6 busy timeout", nc, BW);
      chk(widx == 0, "R6 no payload taken", widx, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule